// File: doc/BRIEF.md
# Bitwise Three-Input Lookup Unit

This block evaluates an arbitrary three-input boolean function on every bit position of a register-wide datapath. For each bit it forms a 3-bit index from the matching bits of three operands and takes the addressed bit of an 8-entry truth table as the result bit. In effect it behaves like a row of small three-input programmable logic cells that share one configuration.

The truth table comes from one of two places. It can be an 8-bit immediate, which arrives split into a 5-bit low part and a 3-bit high part that the block puts back together. It can also be the low byte of a fourth register operand. A whole-word mode reduces each operand to a single zero/nonzero flag and returns one looked-up bit in bit 0 of the result. The first operand is the value that the result overwrites in the register file. The result and its valid flag are registered, so each result appears one cycle after its request.

Top module: `lut3_unit`

## Requirements
- R1: While rst_ni is low, done_o and res_o are 0.
- R2: done_o is high exactly in the cycle after a cycle with req_i high, and low otherwise.
- R3: In bitwise mode (mode_i = 2'b00), bit k of res_o is bit n of the table, where n = {opa_i[k], opb_i[k], opc_i[k]}. opa_i is the most significant index bit.
- R4: When tsel_i = 0, the table is {imm_hi_i[2:0], imm_lo_i[4:0]}, with imm_lo_i forming table bits 4..0.
- R5: When tsel_i = 1, the table is tbl_i[7:0]. The bits of tbl_i above bit 7 have no effect.
- R6: In whole-word mode (mode_i = 2'b01), index bit 2 is 1 if opa_i is nonzero, bit 1 is 1 if opb_i is nonzero, and bit 0 is 1 if opc_i is nonzero. res_o[0] is the looked-up bit and every other bit of res_o is 0.
- R7: Mode values 2'b10 and 2'b11 behave as bitwise mode.
- R8: Table 0xCA gives (opa & opb) | (~opa & opc), table 0x96 gives opa ^ opb ^ opc, and table 0xE8 gives the bitwise majority of the three operands.
- R9: res_o holds its value in any cycle that follows a cycle with req_i low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request strobe |
| opa_i | input | XLEN | First operand, most significant index bit, and the value the result overwrites |
| opb_i | input | XLEN | Second operand, middle index bit |
| opc_i | input | XLEN | Third operand, least significant index bit |
| imm_lo_i | input | 5 | Immediate table bits 4..0 |
| imm_hi_i | input | 3 | Immediate table bits 7..5 |
| tbl_i | input | XLEN | Register table; only bits 7..0 are used |
| tsel_i | input | 1 | Table source: 0 selects the immediate, 1 selects the register |
| mode_i | input | 2 | 00 bitwise, 01 whole-word, 1x bitwise |
| done_o | output | 1 | Result valid |
| res_o | output | XLEN | Result word |

## Verification
Table-source selection and mode selection act on the same request. The bench issues back-to-back requests that switch the register table, the immediate table and whole-word mode from one cycle to the next, with different garbage in the unused input each time. Every request computes its expected word in the bench and pushes it into a queue. A monitor compares each done_o cycle against the head of that queue. This catches a stale table source, or a mode that leaks from one request into the next.

// File: rtl/lut3_pkg.sv
package lut3_pkg;
  typedef enum logic [1:0] {
    MODE_BIT  = 2'b00,
    MODE_WORD = 2'b01,
    MODE_RSV2 = 2'b10,
    MODE_RSV3 = 2'b11
  } lut3_mode_e;

  localparam int unsigned TBL_W = 8;
  localparam int unsigned IMM_LO_W = 5;
  localparam int unsigned IMM_HI_W = TBL_W - IMM_LO_W;
endpackage

// File: rtl/lut3_tbl_sel.sv
module lut3_tbl_sel
  import lut3_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  logic [IMM_LO_W-1:0] imm_lo_i,
  input  logic [IMM_HI_W-1:0] imm_hi_i,
  input  logic [XLEN-1:0]     tbl_i,
  input  logic                tsel_i,
  output logic [TBL_W-1:0]    tbl_o
);
  logic [TBL_W-1:0] imm_tbl;
  assign imm_tbl = {imm_hi_i, imm_lo_i};
  assign tbl_o   = tsel_i ? tbl_i[TBL_W-1:0] : imm_tbl;

  always_comb begin
    if (tsel_i == 1'b0) a_r4_imm_order: assert (tbl_o[IMM_LO_W-1:0] == imm_lo_i);
  end
endmodule

// File: rtl/lut3_bit_array.sv
module lut3_bit_array
  import lut3_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  logic [XLEN-1:0]  opa_i,
  input  logic [XLEN-1:0]  opb_i,
  input  logic [XLEN-1:0]  opc_i,
  input  logic [TBL_W-1:0] tbl_i,
  output logic [XLEN-1:0]  res_o
);
  for (genvar k = 0; k < XLEN; k++) begin : g_cell
    logic [2:0] idx;
    assign idx      = {opa_i[k], opb_i[k], opc_i[k]};
    assign res_o[k] = tbl_i[idx];
  end
endmodule

// File: rtl/lut3_word_eval.sv
module lut3_word_eval
  import lut3_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  logic [XLEN-1:0]  opa_i,
  input  logic [XLEN-1:0]  opb_i,
  input  logic [XLEN-1:0]  opc_i,
  input  logic [TBL_W-1:0] tbl_i,
  output logic [XLEN-1:0]  res_o
);
  logic [2:0] idx;
  assign idx   = {|opa_i, |opb_i, |opc_i};
  assign res_o = {{(XLEN-1){1'b0}}, tbl_i[idx]};
endmodule

// File: rtl/lut3_unit.sv
module lut3_unit
  import lut3_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_i,
  input  logic [XLEN-1:0]     opa_i,
  input  logic [XLEN-1:0]     opb_i,
  input  logic [XLEN-1:0]     opc_i,
  input  logic [4:0]          imm_lo_i,
  input  logic [2:0]          imm_hi_i,
  input  logic [XLEN-1:0]     tbl_i,
  input  logic                tsel_i,
  input  logic [1:0]          mode_i,
  output logic                done_o,
  output logic [XLEN-1:0]     res_o
);
  logic [TBL_W-1:0] tbl;
  logic [XLEN-1:0]  bit_res, word_res, nxt_res;

  lut3_tbl_sel #(.XLEN(XLEN)) i_tbl_sel (
    .imm_lo_i(imm_lo_i), .imm_hi_i(imm_hi_i), .tbl_i(tbl_i),
    .tsel_i(tsel_i), .tbl_o(tbl)
  );

  lut3_bit_array #(.XLEN(XLEN)) i_bit_array (
    .opa_i(opa_i), .opb_i(opb_i), .opc_i(opc_i), .tbl_i(tbl), .res_o(bit_res)
  );

  lut3_word_eval #(.XLEN(XLEN)) i_word_eval (
    .opa_i(opa_i), .opb_i(opb_i), .opc_i(opc_i), .tbl_i(tbl), .res_o(word_res)
  );

  assign nxt_res = (lut3_mode_e'(mode_i) == MODE_WORD) ? word_res : bit_res;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o <= 1'b0;
      res_o  <= '0;
    end else begin
      done_o <= req_i;
      if (req_i) res_o <= nxt_res;
    end
  end

  a_r2_done_follows_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o == $past(req_i));
  a_r9_hold_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> $stable(res_o));
  a_r6_word_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && mode_i == 2'b01) |=> (res_o[XLEN-1:1] == '0));
  a_r8_xor_table: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && mode_i != 2'b01 && tsel_i && tbl_i[7:0] == 8'h96)
      |=> res_o == $past(opa_i ^ opb_i ^ opc_i));
  a_r3_all_zero_idx: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && mode_i == 2'b00 && !tsel_i && opa_i == '0 && opb_i == '0 && opc_i == '0)
      |=> res_o == {XLEN{$past(imm_lo_i[0])}});
endmodule

// File: tb/test_lut3_unit.sv
module test_lut3_unit;
  localparam int unsigned XLEN = 64;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic req = 1'b0, tsel = 1'b0;
  logic [XLEN-1:0] opa = '0, opb = '0, opc = '0, tbl = '0;
  logic [4:0] imm_lo = '0;
  logic [2:0] imm_hi = '0;
  logic [1:0] mode = '0;
  logic done;
  logic [XLEN-1:0] res;

  int checks = 0, errors = 0;
  logic [XLEN-1:0] exp_q[$];
  string tag_q[$];
  bit finished = 1'b0;

  always #5 clk = ~clk;

  lut3_unit #(.XLEN(XLEN)) i_lut3_unit (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .opa_i(opa), .opb_i(opb),
    .opc_i(opc), .imm_lo_i(imm_lo), .imm_hi_i(imm_hi), .tbl_i(tbl),
    .tsel_i(tsel), .mode_i(mode), .done_o(done), .res_o(res)
  );

  function automatic logic [XLEN-1:0] model(logic [XLEN-1:0] a, b, c,
                                            logic [7:0] t, logic [1:0] m);
    logic [XLEN-1:0] r;
    if (m == 2'b01) begin
      r = '0;
      r[0] = t[{a != 0, b != 0, c != 0}];
    end else begin
      for (int k = 0; k < XLEN; k++) r[k] = t[{a[k], b[k], c[k]}];
    end
    return r;
  endfunction

  task automatic check(string tag, logic [XLEN-1:0] act, logic [XLEN-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: act=%h exp=%h", tag, act, exp);
    end
  endtask

  // drive one request in this cycle; expected result goes to the scoreboard
  task automatic issue(string tag, logic [XLEN-1:0] a, b, c, logic [7:0] t,
                       logic use_reg, logic [1:0] m, logic [XLEN-1:0] junk,
                       logic [XLEN-1:0] exp_override = 'x, bit use_ovr = 0);
    opa = a; opb = b; opc = c; mode = m; tsel = use_reg; req = 1'b1;
    if (use_reg) begin
      tbl = {junk[XLEN-1:8], t};
      {imm_hi, imm_lo} = junk[7:0];
    end else begin
      {imm_hi, imm_lo} = t;
      tbl = junk;
    end
    exp_q.push_back(use_ovr ? exp_override : model(a, b, c, t, m));
    tag_q.push_back(tag);
    @(posedge clk); #1;
    req = 1'b0;
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_ni) begin
      if (done) begin
        if (exp_q.size() == 0) check("R2 unexpected done", 1, 0);
        else check(tag_q.pop_front(), res, exp_q.pop_front());
      end
    end
  end

  initial begin
    logic [XLEN-1:0] a, b, c, held;
    #1;
    #20;
    check("R1 res in reset", res, '0);
    check("R1 done in reset", {63'b0, done}, '0);
    @(negedge clk); rst_ni = 1'b1;
    @(posedge clk); #1;

    a = 64'hF0F0_1234_DEAD_BEEF; b = 64'hCCCC_5678_0F0F_AAAA; c = 64'hAAAA_9ABC_FFFF_0000;
    issue("R8 mux 0xCA reg", a, b, c, 8'hCA, 1, 2'b00, 64'h1111_2222_3333_4455, (a & b) | (~a & c), 1);
    issue("R8 xor 0x96 imm", a, b, c, 8'h96, 0, 2'b00, 64'hFFFF_FFFF_FFFF_FFFF, a ^ b ^ c, 1);
    issue("R8 maj 0xE8 reg", a, b, c, 8'hE8, 1, 2'b00, 64'h0, (a & b) | (a & c) | (b & c), 1);
    issue("R4 imm split order", a, b, c, 8'b101_00110, 0, 2'b00, 64'h5A5A_5A5A_5A5A_5A5A);
    issue("R5 tbl upper ignored", a, b, c, 8'h6B, 1, 2'b00, 64'hDEAD_BEEF_CAFE_F00D);
    issue("R3 single minterm 0x80", a, b, c, 8'h80, 0, 2'b00, 64'h0, a & b & c, 1);
    issue("R3 index order 0x02", a, b, c, 8'h02, 1, 2'b00, 64'h0, ~a & ~b & c, 1);
    issue("R6 word all nonzero", 64'h1, 64'h8000_0000_0000_0000, 64'h10, 8'h80, 0, 2'b01, 64'hFF, 64'h1, 1);
    issue("R6 word a zero", 64'h0, 64'h2, 64'h3, 8'h08, 1, 2'b01, 64'hFFFF_FFFF_FFFF_FF00, 64'h1, 1);
    issue("R6 word miss", 64'h0, 64'h2, 64'h3, 8'hF7, 0, 2'b01, 64'h0, 64'h0, 1);
    issue("R7 mode 10 bitwise", a, b, c, 8'h96, 1, 2'b10, 64'h0, a ^ b ^ c, 1);
    issue("R7 mode 11 bitwise", a, b, c, 8'hE8, 0, 2'b11, 64'h0, (a & b) | (a & c) | (b & c), 1);
    for (int n = 0; n < 40; n++) begin
      a = {$urandom, $urandom}; b = {$urandom, $urandom}; c = {$urandom, $urandom};
      issue("R3 random", a, b, c, 8'($urandom), 1'($urandom), 2'($urandom),
            {$urandom, $urandom});
    end
    @(posedge clk); #1;
    held = res;
    opa = ~opa; tbl = ~tbl; mode = 2'b01;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R9 hold while idle", res, held);
    check("R2 done low when idle", {63'b0, done}, '0);
    check("R2 queue drained", 64'(exp_q.size()), 0);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL R2 watchdog: act=hang exp=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule